// File: doc/BRIEF.md
# DRAM ECC Error Status and Capture Logger

This block sits beside a DRAM controller's ECC checker and turns its per-channel error reports into state that host software can read. Each memory channel can report one error event per clock. An event gives the error type (correctable or uncorrectable), the syndrome, and the rank, bank, row and column of the failing access. The block holds one 64-bit capture record for each channel. It also keeps two shared sticky flags, one for correctable and one for uncorrectable errors.

Capture follows a severity rule. An uncorrectable event replaces a held correctable record. A correctable event never replaces any held record. As a result, a record always describes the worst event seen since the last clear. Software reads the flags and records through a small register port. It clears the flags by writing ones to them, and that write also releases the matching records so they can take a new event.

A capability input selects single-channel operation. In that mode only channel 0 is live and channel 1 is held empty.

Top module: `ecc_err_logger`

## Requirements
- R1: A channel record is 64 bits. Column is in 63:48, row in 47:32, bank in 31:29 and rank in 28:27. The syndrome is in 23:16. The uncorrectable flag is bit 1 and the correctable flag is bit 0. Every other bit reads 0, and at most one of the two flag bits is set.
- R2: The status word has the uncorrectable flag at bit 1 and the correctable flag at bit 0, with all other bits 0. A flag is set on any event of its type from a live channel, whether or not that event is logged.
- R3: Writing the status address (0) sets flags back to 0 where the write data bit is 1. Flags whose write data bit is 0 keep their value.
- R4: An uncorrectable event replaces a held correctable record. It is ignored while an uncorrectable record is held.
- R5: A correctable event is recorded only into an empty record. A held correctable or uncorrectable record keeps its contents.
- R6: Clearing a status flag also clears the matching flag bit in every channel record, so that record can capture a new event. The other fields of the record are kept.
- R7: If an event and a clearing write occur in the same cycle, the event wins. Its flag stays set, and the record is judged on its cleared contents, so the new event is recorded.
- R8: While `singleChan` is 1, the channel 1 record reads 0 and channel 1 events set no status flag.
- R9: `rankIdx` holds one 3-bit field per channel, equal to channel × 4 + the rank field of that channel's record.
- R10: Reads return data one cycle after `regRd`, with `rdValid` high for exactly that cycle. Address 0 is status, 1 is channel 0 and 2 is channel 1; any other address reads 0. Writes to addresses other than 0 have no effect.
- R11: After reset, both records and both status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| singleChan | input | 1 | 1 = only channel 0 is live |
| evValid | input | 2 | Per-channel event valid |
| evUncorr | input | 2 | Per-channel type: 1 = uncorrectable, 0 = correctable |
| evSynd | input | 16 | Syndrome, 8 bits per channel |
| evRank | input | 4 | Rank, 2 bits per channel |
| evBank | input | 6 | Bank, 3 bits per channel |
| evRow | input | 32 | Row, 16 bits per channel |
| evCol | input | 32 | Column, 16 bits per channel |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 2 | Write data for the two flag bits (1 = clear) |
| rdValid | output | 1 | Read data valid |
| rdData | output | 64 | Read data |
| rankIdx | output | 6 | Per-channel global rank index, 3 bits each |

## Verification
On every cycle, the assertions check these properties:
- A held uncorrectable record survives anything short of its own clear.
- A record never carries both flag bits.
- An idle channel's record is empty on the following cycle.
- A set request always leaves its flag high.
- Each read strobe is answered one cycle later.

Some behaviour needs concrete sequences, and only the bench's scenarios can show it:
- The contents of a record after a chain of competing events.
- That fields other than the flags survive a clear.
- That a write to a record address is harmless.
- The value of the rank index.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int NUM_CH       = 2;
  localparam int RANKS_PER_CH = 4;
  localparam int SYND_W       = 8;
  localparam int RANK_W       = 2;
  localparam int BANK_W       = 3;
  localparam int ROW_W        = 16;
  localparam int COL_W        = 16;
  localparam int LOG_W        = 64;
  localparam int ADDR_W       = 2;
  localparam int RIDX_W       = $clog2(NUM_CH * RANKS_PER_CH);
  localparam int UE_BIT       = 1;
  localparam int CE_BIT       = 0;
  localparam int RANK_LSB     = 27;
  localparam logic [ADDR_W-1:0] ADDR_STS = '0;

  typedef struct packed {
    logic [NUM_CH-1:0] chOn;
    logic [NUM_CH-1:0] ldLog;
    logic              setUe;
    logic              setCe;
    logic              clrUe;
    logic              clrCe;
    logic              rdStb;
    logic [ADDR_W-1:0] rdSel;
  } ctrlStb_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              singleChan,
  input  logic [NUM_CH-1:0] evValid,
  input  logic [NUM_CH-1:0] evUncorr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        regWdata,
  input  logic [NUM_CH-1:0] heldUe,
  input  logic [NUM_CH-1:0] heldCe,
  output ctrlStb_t          stb
);
  logic [NUM_CH-1:0] ueAfterClr;
  logic [NUM_CH-1:0] ceAfterClr;

  always_comb begin
    stb = '0;
    stb.clrUe = regWr && (regAddr == ADDR_STS) && regWdata[UE_BIT];
    stb.clrCe = regWr && (regAddr == ADDR_STS) && regWdata[CE_BIT];
    stb.rdStb = regRd;
    stb.rdSel = regAddr;
    ueAfterClr = heldUe & {NUM_CH{~stb.clrUe}};
    ceAfterClr = heldCe & {NUM_CH{~stb.clrCe}};
    for (int c = 0; c < NUM_CH; c++) begin
      stb.chOn[c] = (c == 0) ? 1'b1 : ~singleChan;
      if (stb.chOn[c] && evValid[c]) begin
        if (evUncorr[c]) begin
          stb.setUe    = 1'b1;
          stb.ldLog[c] = ~ueAfterClr[c];
        end else begin
          stb.setCe    = 1'b1;
          stb.ldLog[c] = ~(ueAfterClr[c] | ceAfterClr[c]);
        end
      end
    end
  end

  AST_CE_NOT_OVER_UE: assert property (@(posedge clk) disable iff (!rstN)
    (heldUe[0] && !stb.clrUe && !evUncorr[0]) |-> !stb.ldLog[0]); // R5

  AST_IDLE_CH_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !stb.chOn[NUM_CH-1] |-> !stb.ldLog[NUM_CH-1]); // R8
endmodule

// File: rtl/ecc_log_dpath.sv
module ecc_log_dpath
  import ecc_log_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStb_t                 stb,
  input  logic [NUM_CH-1:0]        evUncorr,
  input  logic [NUM_CH*SYND_W-1:0] evSynd,
  input  logic [NUM_CH*RANK_W-1:0] evRank,
  input  logic [NUM_CH*BANK_W-1:0] evBank,
  input  logic [NUM_CH*ROW_W-1:0]  evRow,
  input  logic [NUM_CH*COL_W-1:0]  evCol,
  output logic [NUM_CH-1:0]        heldUe,
  output logic [NUM_CH-1:0]        heldCe,
  output logic                     rdValid,
  output logic [LOG_W-1:0]         rdData,
  output logic [NUM_CH*RIDX_W-1:0] rankIdx
);
  logic [NUM_CH*LOG_W-1:0] logFlat;
  logic stsUe, stsCe;
  logic [LOG_W-1:0] rdMux;

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic [LOG_W-1:0] logQ;
    logic [LOG_W-1:0] record;

    assign record = {evCol[c*COL_W +: COL_W], evRow[c*ROW_W +: ROW_W],
                     evBank[c*BANK_W +: BANK_W], evRank[c*RANK_W +: RANK_W],
                     3'b000, evSynd[c*SYND_W +: SYND_W], 14'd0,
                     evUncorr[c], ~evUncorr[c]};

    always_ff @(posedge clk) begin
      if (!rstN || !stb.chOn[c]) logQ <= '0;
      else if (stb.ldLog[c]) logQ <= record;
      else begin
        if (stb.clrUe) logQ[UE_BIT] <= 1'b0;
        if (stb.clrCe) logQ[CE_BIT] <= 1'b0;
      end
    end

    assign logFlat[c*LOG_W +: LOG_W] = logQ;
    assign heldUe[c] = logQ[UE_BIT];
    assign heldCe[c] = logQ[CE_BIT];
    assign rankIdx[c*RIDX_W +: RIDX_W] =
      RIDX_W'(c * RANKS_PER_CH) + RIDX_W'(logQ[RANK_LSB +: RANK_W]);

    AST_UE_RETAINED: assert property (@(posedge clk) disable iff (!rstN)
      (logQ[UE_BIT] && !stb.clrUe && stb.chOn[c]) |=> logQ[UE_BIT]); // R4

    AST_TYPE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
      $countones(logQ[1:0]) <= 1); // R1

    AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
      !stb.chOn[c] |=> (logQ == '0)); // R8
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsUe <= 1'b0;
      stsCe <= 1'b0;
    end else begin
      if (stb.setUe) stsUe <= 1'b1;
      else if (stb.clrUe) stsUe <= 1'b0;
      if (stb.setCe) stsCe <= 1'b1;
      else if (stb.clrCe) stsCe <= 1'b0;
    end
  end

  always_comb begin
    rdMux = '0;
    if (stb.rdSel == ADDR_STS) rdMux = {{(LOG_W-2){1'b0}}, stsUe, stsCe};
    for (int c = 0; c < NUM_CH; c++)
      if (stb.rdSel == ADDR_W'(c + 1)) rdMux = logFlat[c*LOG_W +: LOG_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdStb;
      if (stb.rdStb) rdData <= rdMux;
    end
  end

  AST_SET_WINS_CE: assert property (@(posedge clk) disable iff (!rstN)
    stb.setCe |=> stsCe); // R7

  AST_SET_WINS_UE: assert property (@(posedge clk) disable iff (!rstN)
    stb.setUe |=> stsUe); // R2

  AST_CLR_CE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrCe && !stb.setCe) |=> !stsCe); // R3

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStb |=> rdValid); // R10
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     singleChan,
  input  logic [NUM_CH-1:0]        evValid,
  input  logic [NUM_CH-1:0]        evUncorr,
  input  logic [NUM_CH*SYND_W-1:0] evSynd,
  input  logic [NUM_CH*RANK_W-1:0] evRank,
  input  logic [NUM_CH*BANK_W-1:0] evBank,
  input  logic [NUM_CH*ROW_W-1:0]  evRow,
  input  logic [NUM_CH*COL_W-1:0]  evCol,
  input  logic                     regRd,
  input  logic                     regWr,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [1:0]               regWdata,
  output logic                     rdValid,
  output logic [LOG_W-1:0]         rdData,
  output logic [NUM_CH*RIDX_W-1:0] rankIdx
);
  ctrlStb_t stb;
  logic [NUM_CH-1:0] heldUe, heldCe;

  ecc_log_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .singleChan(singleChan),
    .evValid(evValid), .evUncorr(evUncorr),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .heldUe(heldUe), .heldCe(heldCe), .stb(stb)
  );

  ecc_log_dpath uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .evUncorr(evUncorr),
    .evSynd(evSynd), .evRank(evRank), .evBank(evBank),
    .evRow(evRow), .evCol(evCol),
    .heldUe(heldUe), .heldCe(heldCe),
    .rdValid(rdValid), .rdData(rdData), .rankIdx(rankIdx)
  );
endmodule

// File: tb/tb_ecc_err_logger.sv
`timescale 1ns/1ps
module tb_ecc_err_logger;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic singleChan = 1'b0;
  logic [1:0] evValid = '0, evUncorr = '0;
  logic [15:0] evSynd = '0;
  logic [3:0] evRank = '0;
  logic [5:0] evBank = '0;
  logic [31:0] evRow = '0, evCol = '0;
  logic regRd = 1'b0, regWr = 1'b0;
  logic [1:0] regAddr = '0, regWdata = '0;
  logic rdValid;
  logic [63:0] rdData;
  logic [5:0] rankIdx;
  int nChecks = 0, nFail = 0;
  logic [63:0] rv;

  always #4 clk = ~clk;

  ecc_err_logger dut (
    .clk(clk), .rstN(rstN), .singleChan(singleChan),
    .evValid(evValid), .evUncorr(evUncorr), .evSynd(evSynd),
    .evRank(evRank), .evBank(evBank), .evRow(evRow), .evCol(evCol),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .rdValid(rdValid), .rdData(rdData), .rankIdx(rankIdx)
  );

  // vector: {expSynd[8], expFlags[2], expSts[2], clr[2], synd[8], uncorr, valid}
  localparam logic [23:0] VEC [12] = '{
    {8'h11, 2'b01, 2'b01, 2'b00, 8'h11, 1'b0, 1'b1},
    {8'h11, 2'b01, 2'b01, 2'b00, 8'h22, 1'b0, 1'b1},
    {8'h33, 2'b10, 2'b11, 2'b00, 8'h33, 1'b1, 1'b1},
    {8'h33, 2'b10, 2'b11, 2'b00, 8'h44, 1'b0, 1'b1},
    {8'h33, 2'b10, 2'b11, 2'b00, 8'h00, 1'b0, 1'b0},
    {8'h33, 2'b10, 2'b10, 2'b01, 8'h00, 1'b0, 1'b0},
    {8'h33, 2'b10, 2'b10, 2'b00, 8'h55, 1'b1, 1'b1},
    {8'h33, 2'b00, 2'b00, 2'b10, 8'h00, 1'b0, 1'b0},
    {8'h66, 2'b01, 2'b01, 2'b01, 8'h66, 1'b0, 1'b1},
    {8'h77, 2'b01, 2'b01, 2'b01, 8'h77, 1'b0, 1'b1},
    {8'h88, 2'b10, 2'b11, 2'b10, 8'h88, 1'b1, 1'b1},
    {8'h88, 2'b00, 2'b00, 2'b11, 8'h00, 1'b0, 1'b0}
  };

  function automatic logic [63:0] expLog(input logic [7:0] s, input logic [1:0] f);
    return {s, 8'h3C, 8'hA5, s, s[4:2], s[1:0], 3'b000, s, 14'd0, f};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle with optional event on channel ch and optional status write
  task automatic step(input int ch, input logic v, input logic u, input logic [7:0] s,
                      input logic wr, input logic [1:0] wa, input logic [1:0] wd);
    @(negedge clk);
    evValid = '0; evValid[ch] = v;
    evUncorr = '0; evUncorr[ch] = u;
    evSynd[ch*8 +: 8] = s;
    evRank[ch*2 +: 2] = s[1:0];
    evBank[ch*3 +: 3] = s[4:2];
    evRow[ch*16 +: 16] = {8'hA5, s};
    evCol[ch*16 +: 16] = {s, 8'h3C};
    regWr = wr; regAddr = wa; regWdata = wd;
    @(negedge clk);
    evValid = '0; regWr = 1'b0; regWdata = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired (R10 read path hung)");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    chk("R11 rdValid idle", {63'd0, rdValid}, 64'd0);
    readReg(2'd0, rv); chk("R11 status", rv, 64'd0);
    readReg(2'd1, rv); chk("R11 log0", rv, 64'd0);
    readReg(2'd2, rv); chk("R11 log1", rv, 64'd0);
    chk("R9 rankIdx at reset", {58'd0, rankIdx}, {58'd0, 3'd4, 3'd0});

    // table walk on channel 0: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 12; i++) begin
      step(0, VEC[i][0], VEC[i][1], VEC[i][9:2], VEC[i][11:10] != 2'b00, 2'd0, VEC[i][11:10]);
      readReg(2'd0, rv);
      chk($sformatf("R2/R3/R7 status row %0d", i), rv, {62'd0, VEC[i][13:12]});
      readReg(2'd1, rv);
      chk($sformatf("R1/R4/R5/R6 log0 row %0d", i), rv, expLog(VEC[i][23:16], VEC[i][15:14]));
    end

    // R10 read latency: valid exactly one cycle after the strobe
    @(negedge clk); regRd = 1'b1; regAddr = 2'd0;
    @(negedge clk); regRd = 1'b0;
    chk("R10 rdValid after strobe", {63'd0, rdValid}, 64'd1);
    @(negedge clk);
    chk("R10 rdValid drops", {63'd0, rdValid}, 64'd0);
    readReg(2'd3, rv); chk("R10 unused address", rv, 64'd0);

    // R10 writes to a record address are ignored
    step(0, 1'b1, 1'b0, 8'h2C, 1'b0, 2'd0, 2'b00);
    step(0, 1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 2'b11);
    readReg(2'd0, rv); chk("R10 status after log write", rv, 64'd1);
    readReg(2'd1, rv); chk("R10 log0 after log write", rv, expLog(8'h2C, 2'b01));

    // channel 1 in dual mode, R9 rank index
    step(1, 1'b1, 1'b0, 8'h9A, 1'b0, 2'd0, 2'b00);
    readReg(2'd2, rv); chk("R1 log1 capture", rv, expLog(8'h9A, 2'b01));
    chk("R9 rankIdx", {58'd0, rankIdx}, {58'd0, 3'd6, 3'd0});

    // R8 single-channel mode
    @(negedge clk); singleChan = 1'b1;
    @(negedge clk);
    readReg(2'd2, rv); chk("R8 log1 emptied", rv, 64'd0);
    step(0, 1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 2'b11);
    readReg(2'd0, rv); chk("R3 status cleared", rv, 64'd0);
    step(1, 1'b1, 1'b1, 8'hE1, 1'b0, 2'd0, 2'b00);
    readReg(2'd0, rv); chk("R8 ch1 event sets no flag", rv, 64'd0);
    readReg(2'd2, rv); chk("R8 log1 stays empty", rv, 64'd0);
    readReg(2'd1, rv); chk("R6 log0 fields kept", rv, expLog(8'h2C, 2'b00));

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule